// File: doc/BRIEF.md
# Functional Unit Operand Upset Injector

This block sits between an issue stage and an integer functional unit, such as an adder, a logic unit or a multiplier/divider. It passes the two operand buses to the unit with no added latency. On selected cycles it inverts exactly one bit of one operand. Upsets are applied only to the operands, so the unit's own logic is never touched. Each functional unit gets its own instance, and every instance has its own configuration inputs. A campaign on one unit type therefore runs apart from campaigns on the others.

A synchronous start pulse begins a campaign. It clears the counters and reloads the pseudo-random generator. Three trigger modes are available. A single-shot mode fires once, a programmable number of cycles after start. An interval mode fires every N cycles. A random mode fires on each cycle with a programmable probability. Injection halts once a programmable budget of intended upsets has been issued. The block counts intended upsets, and also effective upsets, which are those that land on a cycle where the unit has a valid operation. A one-cycle flag and the index of the flipped bit go out with the operands, so that downstream checking can predict the corrupted value.

Top module: `fu_upset_injector`

## Requirements
- R1: While reset is asserted, the operands pass through unchanged, `injected` and `flipIndex` are 0, and all three counters are 0.
- R2: In any cycle without an applied upset, `opAOut`/`opBOut` equal `opAIn`/`opBIn` in the same cycle. No upset is ever applied while `enable` is low or `mode` is 3.
- R3: In a cycle with an applied upset, `{opBOut,opAOut}` equals `{opBIn,opAIn}` with only bit `flipIndex` inverted. Index 0..DATA_W-1 selects operand A and DATA_W..2*DATA_W-1 selects operand B. `injected` is 1 in that cycle and only in such cycles.
- R4: Mode 0 (single shot) applies one upset, in the cycle where `cycleCount` equals `interval`. The cycle counter reads 0 in the first cycle after the start pulse. An interval of 0 never fires.
- R5: Mode 1 (periodic) applies an upset in every cycle where `cycleCount` is a nonzero multiple of `interval`.
- R6: An upset is issued only while `intendedCount` is below `budget`. `intendedCount` increments at the clock edge that schedules an upset.
- R7: Mode 2 (random) uses a 32-bit Galois generator. Each cycle it shifts right, and XORs in 0x80200003 when the bit shifted out is 1. The start pulse loads it with `seed`, or with 1 when `seed` is 0. In a cycle where the generator state is below `probThresh`, the next cycle receives an upset. Its index is the low 16 bits of that state, modulo 2*DATA_W. The single-shot and periodic modes take their index the same way.
- R8: `effectiveCount` increments only when an upset is applied in a cycle with `opValid` high. An upset on a cycle with `opValid` low leaves it unchanged.
- R9: The start pulse sets all counters to 0, cancels any pending upset and schedules none. `cycleCount` then increments by one per cycle. All counters saturate at their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Synchronous campaign start |
| enable | input | 1 | Allows upsets to be scheduled |
| mode | input | 2 | 0 single shot, 1 periodic, 2 random, 3 off |
| interval | input | CNT_W | Delay (mode 0) or period (mode 1) in cycles |
| budget | input | CNT_W | Maximum intended upsets per campaign |
| probThresh | input | 32 | Random-mode threshold, probability times 2^32 |
| seed | input | 32 | Generator seed |
| opValid | input | 1 | Functional unit performs an operation this cycle |
| opAIn | input | DATA_W | Operand A from issue |
| opBIn | input | DATA_W | Operand B from issue |
| opAOut | output | DATA_W | Operand A to the unit |
| opBOut | output | DATA_W | Operand B to the unit |
| injected | output | 1 | An upset is applied this cycle |
| flipIndex | output | IDX_W | Index of the inverted bit, 0 when none |
| intendedCount | output | CNT_W | Upsets issued since start |
| effectiveCount | output | CNT_W | Upsets that landed on valid operations |
| cycleCount | output | CNT_W | Cycles since start |

## Verification
Each campaign is run against an arithmetic model of the schedule and the generator. Every cycle's operands, flag and index are compared with the model, using fresh random operands. The configurations used are these:
- Single shot, at a short delay and at a delay of 100.
- Periodic, at intervals of 1, 2, 3 and 4. Some of these runs are cut short by the budget.
- Random, at thresholds of 0, one quarter and one half, with one run using a zero seed.
- Injection disabled, and the off mode.

These configurations tell apart an off-by-one in the schedule, the budget limit and the seed substitution. The `opValid` input is driven always high, always low and random. Comparing the two counters across these runs separates effective upsets from intended ones.

// File: rtl/fui_pkg.sv
package fui_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_RANDOM   = 2'd2,
    MODE_OFF      = 2'd3
  } injMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic fire;
  } dpStrobe_t;

  localparam int LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;
  localparam int IDX_SRC_W = 16;
endpackage

// File: rtl/fui_lfsr.sv
module fui_lfsr
  import fui_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] stateQ;
  logic [LFSR_W-1:0] seedSafe;
  logic [LFSR_W-1:0] stepped;

  assign seedSafe = (seed == '0) ? LFSR_W'(1) : seed;
  assign stepped  = (stateQ >> 1) ^ (stateQ[0] ? LFSR_TAPS : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     stateQ <= LFSR_W'(1);
    else if (load) stateQ <= seedSafe;
    else           stateQ <= stepped;
  end

  assign state = stateQ;

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != '0);
endmodule

// File: rtl/fui_ctrl.sv
module fui_ctrl
  import fui_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32,
  localparam int TOTAL_W = 2 * DATA_W,
  localparam int IDX_W   = $clog2(TOTAL_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  interval,
  input  logic [CNT_W-1:0]  budget,
  input  logic [LFSR_W-1:0] probThresh,
  input  logic [LFSR_W-1:0] seed,
  input  logic              opValid,
  input  logic              injected,
  output dpStrobe_t         strobe,
  output logic [IDX_W-1:0]  bitIdx,
  output logic [CNT_W-1:0]  intendedCount,
  output logic [CNT_W-1:0]  effectiveCount,
  output logic [CNT_W-1:0]  cycleCount
);
  injMode_e          modeE;
  logic [LFSR_W-1:0] rnd;
  logic [CNT_W-1:0]  cycleQ, phaseQ, intendedQ, effectiveQ;
  logic              phaseWrap, trigger, budgetLeft, fire;
  logic [CNT_W:0]    nextCycle;

  assign modeE = injMode_e'(mode);

  fui_lfsr u_lfsr (
    .clk   (clk),
    .rstN  (rstN),
    .load  (startPulse),
    .seed  (seed),
    .state (rnd)
  );

  assign nextCycle  = {1'b0, cycleQ} + 1'b1;
  assign phaseWrap  = (interval != '0) && (phaseQ == interval - 1'b1);
  assign budgetLeft = intendedQ < budget;

  always_comb begin
    case (modeE)
      MODE_ONESHOT:  trigger = (interval != '0) && (nextCycle == {1'b0, interval});
      MODE_PERIODIC: trigger = phaseWrap;
      MODE_RANDOM:   trigger = rnd < probThresh;
      default:       trigger = 1'b0;
    endcase
  end

  assign fire = enable && budgetLeft && trigger && !startPulse;

  assign strobe.clear = startPulse;
  assign strobe.fire  = fire;
  assign bitIdx = IDX_W'(32'(rnd[IDX_SRC_W-1:0]) % TOTAL_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleQ     <= '0;
      phaseQ     <= '0;
      intendedQ  <= '0;
      effectiveQ <= '0;
    end else if (startPulse) begin
      cycleQ     <= '0;
      phaseQ     <= '0;
      intendedQ  <= '0;
      effectiveQ <= '0;
    end else begin
      if (cycleQ != '1) cycleQ <= cycleQ + 1'b1;
      if (phaseWrap || interval == '0) phaseQ <= '0;
      else                             phaseQ <= phaseQ + 1'b1;
      if (fire && intendedQ != '1) intendedQ <= intendedQ + 1'b1;
      if (injected && opValid && effectiveQ != '1) effectiveQ <= effectiveQ + 1'b1;
    end
  end

  assign intendedCount  = intendedQ;
  assign effectiveCount = effectiveQ;
  assign cycleCount     = cycleQ;

  // R6
  budget_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startPulse && intendedQ >= budget) |=> $stable(intendedQ));

  // R8
  idle_upset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startPulse && injected && !opValid) |=> $stable(effectiveQ));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (cycleQ == '0 && intendedQ == '0 && effectiveQ == '0));

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startPulse && !enable) |=> $stable(intendedQ));
endmodule

// File: rtl/fui_datapath.sv
module fui_datapath
  import fui_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int TOTAL_W = 2 * DATA_W,
  localparam int IDX_W   = $clog2(TOTAL_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] opAIn,
  input  logic [DATA_W-1:0] opBIn,
  output logic [DATA_W-1:0] opAOut,
  output logic [DATA_W-1:0] opBOut,
  output logic              injected,
  output logic [IDX_W-1:0]  flipIndex
);
  logic [TOTAL_W-1:0] maskQ;
  logic [IDX_W-1:0]   idxQ;
  logic [TOTAL_W-1:0] opsIn, opsOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      idxQ  <= '0;
    end else if (strobe.clear || !strobe.fire) begin
      maskQ <= '0;
      idxQ  <= '0;
    end else begin
      maskQ <= TOTAL_W'(1) << bitIdx;
      idxQ  <= bitIdx;
    end
  end

  assign opsIn = {opBIn, opAIn};

  for (genvar g = 0; g < TOTAL_W; g++) begin : g_flip
    assign opsOut[g] = opsIn[g] ^ maskQ[g];
  end

  assign {opBOut, opAOut} = opsOut;
  assign injected  = |maskQ;
  assign flipIndex = idxQ;

  // R3
  single_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opBOut, opAOut} ^ {opBIn, opAIn}));

  // R3
  index_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    injected |-> (({opBOut, opAOut} ^ {opBIn, opAIn}) == (TOTAL_W'(1) << flipIndex)));

  // R2
  passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    !injected |-> ({opBOut, opAOut} == {opBIn, opAIn}));
endmodule

// File: rtl/fu_upset_injector.sv
module fu_upset_injector
  import fui_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  interval,
  input  logic [CNT_W-1:0]  budget,
  input  logic [31:0]       probThresh,
  input  logic [31:0]       seed,
  input  logic              opValid,
  input  logic [DATA_W-1:0] opAIn,
  input  logic [DATA_W-1:0] opBIn,
  output logic [DATA_W-1:0] opAOut,
  output logic [DATA_W-1:0] opBOut,
  output logic              injected,
  output logic [IDX_W-1:0]  flipIndex,
  output logic [CNT_W-1:0]  intendedCount,
  output logic [CNT_W-1:0]  effectiveCount,
  output logic [CNT_W-1:0]  cycleCount
);
  dpStrobe_t        strobe;
  logic [IDX_W-1:0] bitIdx;

  fui_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .startPulse     (startPulse),
    .enable         (enable),
    .mode           (mode),
    .interval       (interval),
    .budget         (budget),
    .probThresh     (probThresh),
    .seed           (seed),
    .opValid        (opValid),
    .injected       (injected),
    .strobe         (strobe),
    .bitIdx         (bitIdx),
    .intendedCount  (intendedCount),
    .effectiveCount (effectiveCount),
    .cycleCount     (cycleCount)
  );

  fui_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bitIdx    (bitIdx),
    .opAIn     (opAIn),
    .opBIn     (opBIn),
    .opAOut    (opAOut),
    .opBOut    (opBOut),
    .injected  (injected),
    .flipIndex (flipIndex)
  );
endmodule

// File: tb/fu_upset_injector_tb.sv
module fu_upset_injector_tb;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 32;
  localparam int TOTAL_W = 2 * DATA_W;
  localparam int IDX_W = $clog2(TOTAL_W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'd3;
  logic [CNT_W-1:0] interval = '0;
  logic [CNT_W-1:0] budget = '0;
  logic [31:0] probThresh = '0;
  logic [31:0] seed = '0;
  logic opValid = 1'b0;
  logic [DATA_W-1:0] opAIn = '0, opBIn = '0;
  logic [DATA_W-1:0] opAOut, opBOut;
  logic injected;
  logic [IDX_W-1:0] flipIndex;
  logic [CNT_W-1:0] intendedCount, effectiveCount, cycleCount;

  int total = 0;
  int errs = 0;

  always #5 clk = ~clk;

  fu_upset_injector #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .enable(enable),
    .mode(mode), .interval(interval), .budget(budget),
    .probThresh(probThresh), .seed(seed), .opValid(opValid),
    .opAIn(opAIn), .opBIn(opBIn), .opAOut(opAOut), .opBOut(opBOut),
    .injected(injected), .flipIndex(flipIndex),
    .intendedCount(intendedCount), .effectiveCount(effectiveCount),
    .cycleCount(cycleCount)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsrStep(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic runCase(input string tag, input logic en, input logic [1:0] md,
                         input logic [31:0] ivl, input logic [31:0] bud,
                         input logic [31:0] thr, input logic [31:0] sd,
                         input int validMode, input int nCyc, input int expInt);
    logic [31:0] mLfsr;
    longint mInt, mEff;
    logic mPend;
    logic [IDX_W-1:0] mIdx;
    enable = en; mode = md; interval = ivl; budget = bud;
    probThresh = thr; seed = sd; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    mLfsr = (sd == 0) ? 32'd1 : sd;
    mInt = 0; mEff = 0; mPend = 1'b0; mIdx = '0;
    // R9: counters cleared by the start pulse
    check(cycleCount == 0 && intendedCount == 0 && effectiveCount == 0,
          "R9", {tag, " start clear"}, {cycleCount, intendedCount}, 64'h0);
    for (int c = 0; c < nCyc; c++) begin
      logic trig, fire;
      logic [TOTAL_W-1:0] expOps;
      opAIn = DATA_W'($urandom);
      opBIn = DATA_W'($urandom);
      opValid = (validMode == 2) ? 1'b1 : (validMode == 1) ? 1'($urandom) : 1'b0;
      #1;
      expOps = {opBIn, opAIn} ^ (mPend ? (TOTAL_W'(1) << mIdx) : '0);
      check({opBOut, opAOut} == expOps, mPend ? "R3" : "R2",
            {tag, " operands"}, 64'({opBOut, opAOut}), 64'(expOps));
      check(injected == mPend, tag, "injected flag", 64'(injected), 64'(mPend));
      check(flipIndex == (mPend ? mIdx : '0), "R3", {tag, " flip index"},
            64'(flipIndex), 64'(mPend ? mIdx : '0));
      check(cycleCount == 32'(c), "R9", {tag, " cycle count"}, 64'(cycleCount), 64'(c));
      if (mPend && opValid) mEff++;
      case (md)
        2'd0: trig = (ivl != 0) && (longint'(c) + 1 == longint'(ivl));
        2'd1: trig = (ivl != 0) && ((longint'(c) + 1) % longint'(ivl) == 0);
        2'd2: trig = mLfsr < thr;
        default: trig = 1'b0;
      endcase
      fire = en && (mInt < longint'(bud)) && trig;
      mPend = fire;
      mIdx = IDX_W'(32'(mLfsr[15:0]) % TOTAL_W);
      if (fire) mInt++;
      mLfsr = lfsrStep(mLfsr);
      @(negedge clk);
    end
    // R6: intended count follows the schedule and the budget
    check(intendedCount == 32'(mInt), "R6", {tag, " intended count"},
          64'(intendedCount), 64'(mInt));
    if (expInt >= 0)
      check(mInt == longint'(expInt) && intendedCount == 32'(expInt), "R6",
            {tag, " intended total"}, 64'(intendedCount), 64'(expInt));
    // R8: effective count only from valid cycles
    check(effectiveCount == 32'(mEff), "R8", {tag, " effective count"},
          64'(effectiveCount), 64'(mEff));
  endtask

  initial begin
    #2ms;
    total++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - errs, total);
    $finish;
  end

  initial begin
    opAIn = 16'h1234; opBIn = 16'hABCD;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({opBOut, opAOut} == 32'hABCD_1234, "R1", "reset passthrough",
          64'({opBOut, opAOut}), 64'h ABCD_1234);
    check(!injected && flipIndex == 0, "R1", "reset flag", 64'({injected, flipIndex}), 64'h0);
    check(intendedCount == 0 && effectiveCount == 0 && cycleCount == 0, "R1",
          "reset counters", 64'(cycleCount), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    runCase("R2 disabled",      1'b0, 2'd1, 3,   10,   0,            32'h5,    1, 30,  0);
    runCase("R2 off mode",      1'b1, 2'd3, 3,   10,   32'hFFFF_FFFF, 32'h7,   1, 30,  0);
    runCase("R4 one-shot 5",    1'b1, 2'd0, 5,   4,    0,            32'hBEEF, 2, 20,  1);
    runCase("R4 one-shot 100",  1'b1, 2'd0, 100, 1,    0,            32'h1357, 1, 120, 1);
    runCase("R4 one-shot zero", 1'b1, 2'd0, 0,   4,    0,            32'h1,    2, 20,  0);
    runCase("R5 periodic 4",    1'b1, 2'd1, 4,   3,    0,            32'h2468, 2, 30,  3);
    runCase("R5 periodic 1",    1'b1, 2'd1, 1,   40,   0,            32'h9,    1, 25,  25);
    runCase("R6 periodic 2",    1'b1, 2'd1, 2,   5,    0,            32'hC0DE, 1, 60,  5);
    runCase("R7 random quarter",1'b1, 2'd2, 0,   1000, 32'h4000_0000, 32'hACE1, 1, 300, -1);
    runCase("R7 random zero seed",1'b1,2'd2, 0,  10,   32'h8000_0000, 32'h0,   2, 100, -1);
    runCase("R7 random none",   1'b1, 2'd2, 0,   1000, 32'h0,        32'h55,   1, 50,  0);
    runCase("R8 idle unit",     1'b1, 2'd1, 3,   20,   0,            32'h3,    0, 30,  10);
    $display("%0d/%0d checks passed", total - errs, total);
    $finish;
  end
endmodule